// File: doc/BRIEF.md
# Signed Multiply-Accumulate Unit

This block is the fixed-point multiply-accumulate datapath of a DSP core. It holds two 16-bit two's-complement operands. One is captured from the data-memory bus and the other from the program-memory bus, each under its own load strobe. A 3-bit operation code from the instruction unit selects one action per clock:
- multiply into the accumulator
- multiply and add
- multiply and subtract
- saturate
- clear
- do nothing

The full 32-bit signed product is sign-extended to a 40-bit accumulator, which gives 8 guard bits. The accumulator is always visible on an output port. A combinational flag reports when its value no longer fits in 32 signed bits. A saturate operation clamps an overflowed value to the largest or smallest 32-bit value, depending on the sign.

Operand registers and the accumulator form a two-stage path. A value loaded on one clock edge is used by operations from the next clock onward.

Top module: `mac_unit`

## Requirements
- R1: While rst_ni is low, and after it is released, the accumulator, both operand registers and the overflow flag are zero.
- R2: At a rising edge with dm_load_i high, operand X takes dm_data_i. At a rising edge with pm_load_i high, operand Y takes pm_data_i. An operation in the same cycle uses the operand values held before that edge.
- R3: Opcode 3'b001 (multiply) sets the accumulator to the signed product X*Y, sign-extended to 40 bits.
- R4: Opcode 3'b010 (multiply-add) adds the sign-extended product to the accumulator, modulo 2^40.
- R5: Opcode 3'b011 (multiply-subtract) subtracts the sign-extended product from the accumulator, modulo 2^40.
- R6: ovf_o is high exactly when accumulator bits 39..31 are not all equal. It follows the accumulator without a register delay, and -2^31 does not count as overflow.
- R7: Opcode 3'b100 (saturate) replaces an overflowed accumulator with 40'h007FFFFFFF when bit 39 is 0, or with 40'hFF80000000 when bit 39 is 1. A non-overflowed accumulator is left unchanged.
- R8: Opcode 3'b101 (clear) zeroes the accumulator and both operand registers. Operand loads in the same cycle are ignored.
- R9: Opcode 3'b000 (idle) and the unused codes 3'b110 and 3'b111 leave the accumulator unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dm_load_i | input | 1 | Load operand X from dm_data_i |
| dm_data_i | input | 16 | Data-memory bus value |
| pm_load_i | input | 1 | Load operand Y from pm_data_i |
| pm_data_i | input | 16 | Program-memory bus value |
| op_i | input | 3 | Operation code |
| acc_o | output | 40 | Accumulator value |
| ovf_o | output | 1 | Accumulator exceeds 32-bit signed range |

## Verification
Assertions check the following on every cycle:
- clear zeroes all state even when a load is requested
- idle and unused codes hold the accumulator
- saturate always leaves the flag low and never alters a value that was in range
- a load without a clear captures the bus value

The arithmetic results can only be shown by the bench's scenarios. These include the signed products at the operand extremes and the same-cycle load and operate ordering. They also include the positive and negative overflow thresholds, with -2^31 as the boundary that must not raise the flag, and the clamp values that saturate produces.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [2:0] {
    OP_IDLE = 3'b000,
    OP_MUL  = 3'b001,
    OP_MAC  = 3'b010,
    OP_MSU  = 3'b011,
    OP_SAT  = 3'b100,
    OP_CLR  = 3'b101
  } mac_op_e;
endpackage

// File: rtl/mac_operand_reg.sv
module mac_operand_reg #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (clr_i)  q_o <= '0;
    else if (load_i) q_o <= data_i;
  end

  assert_clr_over_load_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (q_o == '0));
  assert_load_capture_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !clr_i) |=> (q_o == $past(data_i)));
endmodule

// File: rtl/mac_ovf_detect.sv
module mac_ovf_detect #(
  parameter int ACC_W  = 40,
  parameter int PROD_W = 32
) (
  input  logic [ACC_W-1:0] acc_i,
  output logic             ovf_o
);
  localparam int TOP_W = ACC_W - PROD_W + 1;
  logic [TOP_W-1:0] top;
  assign top   = acc_i[ACC_W-1:PROD_W-1];
  assign ovf_o = !((&top) || (~|top));
endmodule

// File: rtl/mac_acc_next.sv
module mac_acc_next
  import mac_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int GUARD_W = 8
) (
  input  logic [2:0]                        op_i,
  input  logic [DATA_W-1:0]                 x_i,
  input  logic [DATA_W-1:0]                 y_i,
  input  logic [2*DATA_W+GUARD_W-1:0]       acc_i,
  input  logic                              ovf_i,
  output logic [2*DATA_W+GUARD_W-1:0]       acc_o
);
  localparam int PROD_W = 2 * DATA_W;
  localparam int ACC_W  = PROD_W + GUARD_W;
  localparam logic [ACC_W-1:0] SAT_POS = {{(GUARD_W+1){1'b0}}, {(PROD_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] SAT_NEG = {{(GUARD_W+1){1'b1}}, {(PROD_W-1){1'b0}}};

  logic signed [PROD_W-1:0] xs, ys, prod;
  logic [ACC_W-1:0]         prod_ext;
  mac_op_e                  op;

  assign op       = mac_op_e'(op_i);
  assign xs       = {{DATA_W{x_i[DATA_W-1]}}, x_i};
  assign ys       = {{DATA_W{y_i[DATA_W-1]}}, y_i};
  assign prod     = xs * ys;
  assign prod_ext = {{GUARD_W{prod[PROD_W-1]}}, prod};

  always_comb begin
    acc_o = acc_i;
    unique case (op)
      OP_MUL: acc_o = prod_ext;
      OP_MAC: acc_o = acc_i + prod_ext;
      OP_MSU: acc_o = acc_i - prod_ext;
      OP_SAT: if (ovf_i) acc_o = acc_i[ACC_W-1] ? SAT_NEG : SAT_POS;
      OP_CLR: acc_o = '0;
      default: acc_o = acc_i;
    endcase
  end
endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int GUARD_W = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          dm_load_i,
  input  logic [DATA_W-1:0]             dm_data_i,
  input  logic                          pm_load_i,
  input  logic [DATA_W-1:0]             pm_data_i,
  input  logic [2:0]                    op_i,
  output logic [2*DATA_W+GUARD_W-1:0]   acc_o,
  output logic                          ovf_o
);
  localparam int PROD_W = 2 * DATA_W;
  localparam int ACC_W  = PROD_W + GUARD_W;

  logic              clr;
  logic [DATA_W-1:0] x_q, y_q;
  logic [ACC_W-1:0]  acc_q, acc_d;
  logic              ovf;

  assign clr = (op_i == OP_CLR);

  mac_operand_reg #(.W(DATA_W)) u_x_reg (
    .clk_i, .rst_ni, .clr_i(clr), .load_i(dm_load_i), .data_i(dm_data_i), .q_o(x_q));
  mac_operand_reg #(.W(DATA_W)) u_y_reg (
    .clk_i, .rst_ni, .clr_i(clr), .load_i(pm_load_i), .data_i(pm_data_i), .q_o(y_q));

  mac_ovf_detect #(.ACC_W(ACC_W), .PROD_W(PROD_W)) u_ovf (.acc_i(acc_q), .ovf_o(ovf));

  mac_acc_next #(.DATA_W(DATA_W), .GUARD_W(GUARD_W)) u_next (
    .op_i, .x_i(x_q), .y_i(y_q), .acc_i(acc_q), .ovf_i(ovf), .acc_o(acc_d));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_d;
  end

  assign acc_o = acc_q;
  assign ovf_o = ovf;

  assert_clear_all_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> (acc_q == '0 && x_q == '0 && y_q == '0 && !ovf_o));
  assert_hold_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'b000 || op_i == 3'b110 || op_i == 3'b111) |=> $stable(acc_q));
  assert_sat_clears_ovf_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_SAT) |=> !ovf_o);
  assert_sat_keeps_inrange_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_SAT && !ovf_o) |=> $stable(acc_q));
endmodule

// File: tb/mac_unit_test.sv
module mac_unit_test;
  logic        clk_i = 0;
  logic        rst_ni = 0;
  logic        dm_load_i = 0, pm_load_i = 0;
  logic [15:0] dm_data_i = '0, pm_data_i = '0;
  logic [2:0]  op_i = 3'b000;
  logic [39:0] acc_o;
  logic        ovf_o;
  int          n_run = 0, n_fail = 0;

  always #2 clk_i = ~clk_i;

  mac_unit uut (.*);

  task automatic chk(string req, logic [39:0] act, logic [39:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(logic [2:0] op, logic dl, logic [15:0] dd, logic pl, logic [15:0] pd);
    @(negedge clk_i);
    op_i = op; dm_load_i = dl; dm_data_i = dd; pm_load_i = pl; pm_data_i = pd;
    @(posedge clk_i);
    #1;
  endtask

  task automatic t_reset();
    chk("R1 acc", acc_o, 40'h0);
    chk("R1 ovf", {39'h0, ovf_o}, 40'h0);
    step(3'b001, 0, 0, 0, 0);
    chk("R1 operands zero", acc_o, 40'h0);
  endtask

  task automatic t_load_mul();
    step(3'b000, 1, 16'd3, 1, 16'hFFFB);
    chk("R9 idle hold", acc_o, 40'h0);
    step(3'b001, 1, 16'd7, 1, 16'd2);
    chk("R2 same-cycle uses old operands, R3", acc_o, 40'hFFFFFFFFF1);
    step(3'b001, 0, 0, 0, 0);
    chk("R3 multiply", acc_o, 40'h0E);
  endtask

  task automatic t_accum();
    step(3'b010, 0, 0, 0, 0);
    chk("R4 multiply-add", acc_o, 40'h1C);
    step(3'b011, 1, 16'hFFFF, 0, 0);
    chk("R5 multiply-subtract", acc_o, 40'h0E);
    step(3'b011, 0, 0, 0, 0);
    chk("R5 subtract negative product", acc_o, 40'h10);
    step(3'b001, 1, 16'h8000, 1, 16'h7FFF);
    chk("R3 multiply neg", acc_o, 40'hFFFFFFFFFE);
    step(3'b001, 0, 0, 0, 0);
    chk("R3 extremes", acc_o, 40'hFFC0008000);
  endtask

  task automatic t_ovf_pos();
    step(3'b101, 0, 0, 0, 0);
    step(3'b000, 1, 16'h8000, 1, 16'h8000);
    step(3'b010, 0, 0, 0, 0);
    chk("R4 add 2^30", acc_o, 40'h0040000000);
    chk("R6 no ovf", {39'h0, ovf_o}, 40'h0);
    step(3'b010, 0, 0, 0, 0);
    chk("R4 add 2^31", acc_o, 40'h0080000000);
    chk("R6 ovf pos", {39'h0, ovf_o}, 40'h1);
    step(3'b110, 0, 0, 0, 0);
    chk("R9 code 110 hold", acc_o, 40'h0080000000);
    step(3'b111, 0, 0, 0, 0);
    chk("R9 code 111 hold", acc_o, 40'h0080000000);
    step(3'b100, 0, 0, 0, 0);
    chk("R7 sat pos", acc_o, 40'h007FFFFFFF);
    chk("R6 ovf cleared", {39'h0, ovf_o}, 40'h0);
    step(3'b100, 0, 0, 0, 0);
    chk("R7 sat in range unchanged", acc_o, 40'h007FFFFFFF);
  endtask

  task automatic t_ovf_neg();
    step(3'b101, 0, 0, 0, 0);
    step(3'b000, 1, 16'h8000, 1, 16'h8000);
    step(3'b011, 0, 0, 0, 0);
    step(3'b011, 0, 0, 0, 0);
    chk("R5 reach -2^31", acc_o, 40'hFF80000000);
    chk("R6 -2^31 not ovf", {39'h0, ovf_o}, 40'h0);
    step(3'b100, 0, 0, 0, 0);
    chk("R7 sat boundary unchanged", acc_o, 40'hFF80000000);
    step(3'b011, 0, 0, 0, 0);
    chk("R5 below -2^31", acc_o, 40'hFF40000000);
    chk("R6 ovf neg", {39'h0, ovf_o}, 40'h1);
    step(3'b100, 0, 0, 0, 0);
    chk("R7 sat neg", acc_o, 40'hFF80000000);
  endtask

  task automatic t_clear();
    step(3'b001, 0, 0, 0, 0);
    step(3'b101, 1, 16'd9, 1, 16'd9);
    chk("R8 clear acc", acc_o, 40'h0);
    step(3'b001, 0, 0, 0, 0);
    chk("R8 loads ignored on clear", acc_o, 40'h0);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    chk("R1 acc in reset", acc_o, 40'h0);
    @(negedge clk_i);
    rst_ni = 1;
    @(posedge clk_i);
    #1;
    t_reset();
    t_load_mul();
    t_accum();
    t_ovf_pos();
    t_ovf_neg();
    t_clear();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule